// File: doc/BRIEF.md
# Serial Pattern Propagation Grader

The block checks a long serial delay chain by sending a short fixed burst into it and watching a single output tap. After a start request it drives a twelve-bit burst with six ones onto its launch pin, one bit per clock. It then drives zeros until the run ends. During the run it samples the tap every clock. It notes the cycle of the first one that arrives, counts all ones, and compares the spacing of the arrivals with the burst.

When the observation window closes, the block reports one result for the run. The result has a two-bit grade, the measured delay in clock periods, and the number of chain stages that were skipped. The skipped count is the expected delay minus the measured delay. The expected delay is presented at start and held for the whole run. The window is the expected delay plus the burst length plus a fixed margin. The block is meant to sit beside a chain under test, which is re-run at each operating point by outside control.

Top module: `pattern_grader`

## Requirements
- R1: A start request accepted in idle is followed by the run's first cycle (cycle 0). In run cycle i, `launch_o` carries burst bit i, least significant bit first, for i below the burst length; otherwise it is 0. The default burst is 12'h699, which holds six ones.
- R2: `expected_i` is captured on the accepted start and later changes have no effect. A start request made while a run is in progress is ignored and does not move the report cycle.
- R3: `done_o` is a one-cycle pulse in run cycle T = expected + burst length + margin (default margin 16). While `done_o` is low, the grade, delay and missing outputs are all zero.
- R4: Grade 2'b00 (correct) is reported when the tap shows exactly the burst with its original spacing and the measured delay equals the expected delay. The missing count is then 0.
- R5: Grade 2'b01 (short) is reported for an undistorted burst copy whose measured delay is below the expected delay. The missing count equals expected minus measured.
- R6: Grade 2'b10 (distorted) is reported when the tap shows the right number of ones with spacing different from the burst, whatever the delay. The missing count is 0.
- R7: Grade 2'b11 (fail) is reported when no one arrives, when the count of ones differs from the burst's, or when an undistorted copy arrives later than expected. The missing count is 0.
- R8: The measured delay equals the run cycle of the first one seen at the tap minus the position of the first one in the burst. The tap is sampled in run cycles 0 to T-1 only. The delay is 0 when no one was seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Request to begin a run (taken only in idle) |
| expected_i | input | 18 | Designed chain delay in clock periods |
| launch_o | output | 1 | Serial data into the chain |
| tap_i | input | 1 | Serial data observed at the chain tap |
| done_o | output | 1 | One-cycle result strobe |
| grade_o | output | 2 | 00 correct, 01 short, 10 distorted, 11 fail |
| delay_o | output | 18 | Measured delay in clock periods |
| missing_o | output | 18 | Expected minus measured delay for short runs |

## Verification
The launch bit for run cycle i is due in that same cycle. The report is due exactly T cycles after the first launch cycle. The bench numbers every cycle of a run from the falling edge after the accepted start, and it samples outputs and drives the tap at falling edges. A tap value driven in cycle k is therefore taken by the rising edge that ends cycle k. The bench compares the launch bit in every cycle and expects `done_o` in cycle T and not before. Grade, delay and missing are predicted from a bench model of the chain, in which stages can be skipped, two neighbouring bits swapped, a stray one added, or all data dropped.

// File: rtl/pgrade_pkg.sv
// Shared types and constant helpers for the pattern grader.
// Assumes bursts of at most 64 bits.
package pgrade_pkg;

    typedef enum logic [1:0] {
        GR_MATCH = 2'b00,
        GR_SHORT = 2'b01,
        GR_SKEW  = 2'b10,
        GR_FAIL  = 2'b11
    } grade_t;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'b00,
        PH_RUN    = 2'b01,
        PH_REPORT = 2'b10
    } phase_t;

    // Position of the lowest set bit among the first n bits, n if none.
    function automatic int lowest_one(input logic [63:0] v, input int n);
        int r;
        r = n;
        for (int i = n - 1; i >= 0; i--) begin
            if (v[i]) r = i;
        end
        return r;
    endfunction

    // Position of the highest set bit among the first n bits, 0 if none.
    function automatic int highest_one(input logic [63:0] v, input int n);
        int r;
        r = 0;
        for (int i = 0; i < n; i++) begin
            if (v[i]) r = i;
        end
        return r;
    endfunction

    // Number of set bits among the first n bits.
    function automatic int count_ones(input logic [63:0] v, input int n);
        int r;
        r = 0;
        for (int i = 0; i < n; i++) begin
            if (v[i]) r++;
        end
        return r;
    endfunction

endpackage

// File: rtl/burst_source.sv
// Serialises the reference burst onto the launch pin, LSB first.
// Assumes load and shift are never high in the same cycle.
module burst_source #(
    parameter int                   BURST_LEN = 12,
    parameter logic [BURST_LEN-1:0] BURST     = 12'h699
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic shift_i,
    output logic launch_o
);

    logic [BURST_LEN-1:0] sreg;

    // Load the burst on start, then drain one bit per run cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg <= '0;
        end else if (load_i) begin
            sreg <= BURST;
        end else if (shift_i) begin
            sreg <= sreg >> 1;
        end
    end

    assign launch_o = shift_i & sreg[0];

    // R1
    burst_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_i && !load_i) |=> ($countones(sreg) <= $past($countones(sreg))));

endmodule

// File: rtl/tap_monitor.sv
// Watches the chain tap during a run. It records the cycle of the first one,
// counts ones (saturating), and flags any spacing mismatch against the burst.
// Assumes clear_i arrives before the first sample of each run.
module tap_monitor
    import pgrade_pkg::*;
#(
    parameter int                   BURST_LEN = 12,
    parameter logic [BURST_LEN-1:0] BURST     = 12'h699,
    parameter int                   RUN_W     = 19,
    parameter int                   ONE_W     = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             sample_i,
    input  logic [RUN_W-1:0] cyc_i,
    input  logic             tap_i,
    output logic             seen_o,
    output logic [RUN_W-1:0] first_o,
    output logic [ONE_W-1:0] ones_o,
    output logic             shape_ok_o
);

    localparam int FIRST_ONE = lowest_one(64'(BURST), BURST_LEN);
    localparam int LAST_ONE  = highest_one(64'(BURST), BURST_LEN);
    localparam int SPAN      = LAST_ONE - FIRST_ONE + 1;
    localparam int IDX_W     = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
    localparam logic [BURST_LEN-1:0] ALIGNED = BURST >> FIRST_ONE;
    localparam logic [ONE_W-1:0]     ONE_MAX = '1;

    logic [RUN_W-1:0] rel;
    logic             in_win;
    logic             ref_bit;

    // Offset of the current sample from the first arrival, and the burst bit due there.
    always_comb begin
        rel     = cyc_i - first_o;
        in_win  = rel < RUN_W'(SPAN);
        ref_bit = in_win ? ALIGNED[rel[IDX_W-1:0]] : 1'b0;
    end

    // Record the first arrival and track the count and spacing of ones.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            seen_o     <= 1'b0;
            first_o    <= '0;
            ones_o     <= '0;
            shape_ok_o <= 1'b1;
        end else if (sample_i) begin
            if (tap_i && ones_o != ONE_MAX) begin
                ones_o <= ones_o + 1'b1;
            end
            if (!seen_o) begin
                if (tap_i) begin
                    seen_o  <= 1'b1;
                    first_o <= cyc_i;
                end
            end else if (in_win && (tap_i != ref_bit)) begin
                shape_ok_o <= 1'b0;
            end
        end
    end

    // R8
    first_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_o && !clear_i) |=> $stable(first_o));

    // R7
    ones_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_i && !clear_i) |=> (ones_o >= $past(ones_o)));

endmodule

// File: rtl/grade_decider.sv
// Turns the monitor's run record into grade, measured delay and missing count.
// Assumes the expected delay plus the window fits the delay width.
module grade_decider
    import pgrade_pkg::*;
#(
    parameter int                   BURST_LEN = 12,
    parameter logic [BURST_LEN-1:0] BURST     = 12'h699,
    parameter int                   CNT_W     = 18,
    parameter int                   RUN_W     = 19,
    parameter int                   ONE_W     = 5
) (
    input  logic             seen_i,
    input  logic [RUN_W-1:0] first_i,
    input  logic [ONE_W-1:0] ones_i,
    input  logic             shape_ok_i,
    input  logic [CNT_W-1:0] exp_i,
    output grade_t           grade_o,
    output logic [CNT_W-1:0] delay_o,
    output logic [CNT_W-1:0] missing_o
);

    localparam int FIRST_ONE = lowest_one(64'(BURST), BURST_LEN);
    localparam int N_ONES    = count_ones(64'(BURST), BURST_LEN);

    logic [RUN_W-1:0] meas;
    logic [RUN_W-1:0] expw;
    logic             early;

    // Classify the run and derive the delay figures.
    always_comb begin
        meas      = first_i - RUN_W'(FIRST_ONE);
        expw      = {{(RUN_W-CNT_W){1'b0}}, exp_i};
        early     = first_i < RUN_W'(FIRST_ONE);
        grade_o   = GR_FAIL;
        delay_o   = '0;
        missing_o = '0;
        if (seen_i && !early) begin
            delay_o = meas[CNT_W-1:0];
            if (ones_i == ONE_W'(N_ONES)) begin
                if (!shape_ok_i) begin
                    grade_o = GR_SKEW;
                end else if (meas == expw) begin
                    grade_o = GR_MATCH;
                end else if (meas < expw) begin
                    grade_o   = GR_SHORT;
                    missing_o = CNT_W'(expw - meas);
                end
            end
        end
    end

endmodule

// File: rtl/pattern_grader.sv
// Top of the grader. It sequences idle, run and report, holds the run cycle
// count and the captured expected delay, and presents one result per run.
// Assumes expected_i + BURST_LEN + MARGIN stays below 2**CNT_W.
module pattern_grader
    import pgrade_pkg::*;
#(
    parameter int                   CNT_W     = 18,
    parameter int                   BURST_LEN = 12,
    parameter logic [BURST_LEN-1:0] BURST     = 12'h699,
    parameter int                   MARGIN    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] expected_i,
    output logic             launch_o,
    input  logic             tap_i,
    output logic             done_o,
    output logic [1:0]       grade_o,
    output logic [CNT_W-1:0] delay_o,
    output logic [CNT_W-1:0] missing_o
);

    localparam int              RUN_W = CNT_W + 1;
    localparam int              ONE_W = $clog2(BURST_LEN + 1) + 1;
    localparam logic [RUN_W-1:0] EXTRA = RUN_W'(BURST_LEN + MARGIN);

    phase_t           phase;
    logic [RUN_W-1:0] cyc;
    logic [CNT_W-1:0] exp_q;
    logic [RUN_W-1:0] tmo;
    logic             accept;
    logic             sample;

    logic             seen;
    logic [RUN_W-1:0] first_cyc;
    logic [ONE_W-1:0] ones;
    logic             shape_ok;
    grade_t           dec_grade;
    logic [CNT_W-1:0] dec_delay;
    logic [CNT_W-1:0] dec_missing;

    // Run length and control strobes.
    always_comb begin
        tmo    = {1'b0, exp_q} + EXTRA;
        accept = (phase == PH_IDLE) && start_i;
        sample = (phase == PH_RUN);
    end

    // Phase sequencing, run cycle count and expected-delay capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cyc   <= '0;
            exp_q <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (start_i) begin
                        phase <= PH_RUN;
                        cyc   <= '0;
                        exp_q <= expected_i;
                    end
                end
                PH_RUN: begin
                    cyc <= cyc + 1'b1;
                    if (cyc == tmo - 1'b1) begin
                        phase <= PH_REPORT;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    burst_source #(
        .BURST_LEN(BURST_LEN),
        .BURST    (BURST)
    ) u_src (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (accept),
        .shift_i (sample),
        .launch_o(launch_o)
    );

    tap_monitor #(
        .BURST_LEN(BURST_LEN),
        .BURST    (BURST),
        .RUN_W    (RUN_W),
        .ONE_W    (ONE_W)
    ) u_mon (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (accept),
        .sample_i  (sample),
        .cyc_i     (cyc),
        .tap_i     (tap_i),
        .seen_o    (seen),
        .first_o   (first_cyc),
        .ones_o    (ones),
        .shape_ok_o(shape_ok)
    );

    grade_decider #(
        .BURST_LEN(BURST_LEN),
        .BURST    (BURST),
        .CNT_W    (CNT_W),
        .RUN_W    (RUN_W),
        .ONE_W    (ONE_W)
    ) u_dec (
        .seen_i    (seen),
        .first_i   (first_cyc),
        .ones_i    (ones),
        .shape_ok_i(shape_ok),
        .exp_i     (exp_q),
        .grade_o   (dec_grade),
        .delay_o   (dec_delay),
        .missing_o (dec_missing)
    );

    // Result outputs are live only during the report cycle.
    always_comb begin
        done_o    = (phase == PH_REPORT);
        grade_o   = done_o ? dec_grade   : 2'b00;
        delay_o   = done_o ? dec_delay   : '0;
        missing_o = done_o ? dec_missing : '0;
    end

    // R1
    first_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (launch_o == BURST[0]));

    // R2
    exp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_RUN) |=> $stable(exp_q));

    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R4
    match_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && grade_o == GR_MATCH) |-> (missing_o == '0 && delay_o == exp_q));

    // R5
    short_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && grade_o == GR_SHORT) |->
            (missing_o != '0 && CNT_W'(missing_o + delay_o) == exp_q));

    // R7
    fail_nomiss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && grade_o == GR_FAIL) |-> (missing_o == '0));

endmodule

// File: tb/tb_pattern_grader.sv
module tb_pattern_grader;

    localparam int          BL     = 12;
    localparam int          MARGIN = 16;
    localparam logic [11:0] PAT    = 12'h699;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [17:0] exp_in = '0;
    logic        tap = 1'b0;
    logic        launch;
    logic        done;
    logic [1:0]  grade;
    logic [17:0] delay;
    logic [17:0] missing;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;
    bit hist [0:1023];

    pattern_grader dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .expected_i(exp_in),
        .launch_o(launch), .tap_i(tap), .done_o(done), .grade_o(grade),
        .delay_o(delay), .missing_o(missing)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    function automatic bit pat_at(input int i);
        return (i >= 0 && i < BL) ? PAT[i] : 1'b0;
    endfunction

    // Spec-level prediction of the result for one chain model.
    // mode 0 clean, 1 swap bits sp/sp+1, 2 stray one at 14, 3 all dropped
    task automatic predict(input int exp, input int deff, input int mode, input int sp,
                           output int g, output int d, output int m);
        bit mp [0:15];
        int f, pf, ones;
        bit same, tmp;
        for (int i = 0; i < 16; i++) mp[i] = pat_at(i);
        if (mode == 1) begin tmp = mp[sp]; mp[sp] = mp[sp+1]; mp[sp+1] = tmp; end
        if (mode == 2) mp[14] = 1'b1;
        if (mode == 3) for (int i = 0; i < 16; i++) mp[i] = 1'b0;
        f = -1; ones = 0; pf = -1;
        for (int i = 0; i < 16; i++) begin
            if (mp[i]) begin ones++; if (f < 0) f = i; end
        end
        for (int i = BL - 1; i >= 0; i--) if (PAT[i]) pf = i;
        g = 3; d = 0; m = 0;
        if (f < 0) return;
        d = deff + f - pf;
        if (ones != 6) return;
        same = 1;
        for (int i = 0; i < 16; i++) if (mp[i] != pat_at(i - f + pf)) same = 0;
        if (!same) g = 2;
        else if (d == exp) g = 0;
        else if (d < exp) begin g = 1; m = exp - d; end
    endtask

    task automatic run_case(input int exp, input int deff, input int mode,
                            input int sp, input bit busy_start);
        int g, d, m, k, tmo, jj, idx, dk;
        bit got, launch_ok, quiet_ok, v;
        int gg, gd, gm;
        string rq;
        predict(exp, deff, mode, sp, g, d, m);
        rq = (g == 0) ? "R4" : (g == 1) ? "R5" : (g == 2) ? "R6" : "R7";
        @(negedge clk);
        exp_in = 18'(exp);
        start  = 1'b1;
        tap    = 1'b0;
        @(negedge clk);
        start  = 1'b0;
        exp_in = 18'($urandom_range(0, 5000));  // R2: ignored after capture
        tmo = exp + BL + MARGIN;
        got = 0; k = 0; launch_ok = 1; quiet_ok = 1; gg = 0; gd = 0; gm = 0; dk = -1;
        while (!got && k <= tmo + 4) begin
            if (k < 1024) hist[k] = launch;
            if (launch !== pat_at(k)) launch_ok = 0;
            if (done) begin
                got = 1; dk = k; gg = int'(grade); gd = int'(delay); gm = int'(missing);
            end else if (grade != 0 || delay != 0 || missing != 0) begin
                quiet_ok = 0;
            end
            idx = k - deff;
            v = 1'b0;
            if (idx >= 0 && idx < 16) begin
                jj = idx;
                if (mode == 1 && idx == sp) jj = sp + 1;
                if (mode == 1 && idx == sp + 1) jj = sp;
                v = hist[jj];
                if (mode == 2 && idx == 14) v = 1'b1;
                if (mode == 3) v = 1'b0;
            end
            tap = v;
            start = (busy_start && k == 5) ? 1'b1 : 1'b0;  // R2: start while busy
            if (!got) begin
                @(negedge clk);
                k++;
            end
        end
        start = 1'b0;
        tap   = 1'b0;
        check(launch_ok, "R1", "launch bit sequence", launch_ok, 1);
        check(got && dk == tmo, "R3", "done cycle", dk, tmo);
        if (busy_start) check(got && dk == tmo, "R2", "busy start ignored, done cycle", dk, tmo);
        check(quiet_ok, "R3", "outputs zero before done", quiet_ok, 1);
        check(gg == g, rq, "grade", gg, g);
        check(gd == d, "R8", "measured delay", gd, d);
        check(gm == m, (g == 1) ? "R5" : rq, "missing count", gm, m);
        @(negedge clk);
        check(!done, "R3", "done width", done, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check(!done && !launch && grade == 0, "R3", "reset outputs idle", done, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!launch, "R1", "launch quiet in idle", launch, 0);

        run_case(100, 100, 0, 0, 0);  // R4 exact
        run_case(100, 38, 0, 0, 0);   // R5 short, missing 62
        run_case(1, 1, 0, 0, 0);      // R4 minimum delay
        run_case(30, 1, 0, 0, 1);     // R5 plus R2 busy start
        run_case(50, 53, 0, 0, 0);    // R7 late
        run_case(40, 40, 3, 0, 0);    // R7 nothing arrives
        run_case(60, 55, 2, 0, 0);    // R7 stray one
        run_case(80, 80, 1, 0, 0);    // R6 first bit moved
        run_case(80, 70, 1, 4, 0);    // R6 swap inside burst

        for (int t = 0; t < 30; t++) begin
            int e, de, mo, s;
            e  = int'($urandom_range(20, 300));
            de = e - 20 + int'($urandom_range(0, 23));
            if (de < 1) de = 1;
            mo = int'($urandom_range(0, 3));
            s  = int'($urandom_range(0, 10));
            run_case(e, de, mo, s, bit'($urandom_range(0, 1)));
        end

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule